// File: doc/BRIEF.md
# Serial Register Loading Interface

This block is the write-only configuration port of a waveform synthesis core. A host sends 16-bit words over three wires: a serial clock, a data line, and an active-low frame select. The block shifts each word in and moves the completed word into the master clock domain. It then decodes the word into a control register, two 28-bit frequency tuning registers and two 12-bit phase offset registers. The register contents and the control flags are presented as parallel outputs to the synthesis core.

A 28-bit frequency value is loaded in one of two ways, chosen by control flags. In the first, a single write replaces one 14-bit half and leaves the other half alone. In the second, two consecutive writes carry the lower half and then the upper half. The register changes only when the upper half arrives, so the core never sees a half-old, half-new tuning word.

Top module: `serial_reg_loader`

## Requirements
- R1: After `rst_n` is low, every frequency and phase output and every control flag output is zero.
- R2: A word is 16 bits, sent most significant bit first and sampled on falling `sclk` edges while `fsync_n` is low. Bits [15:14] select the target: 00 control, 01 frequency 0, 10 frequency 1, 11 phase.
- R3: If `fsync_n` rises before the 16th falling edge, the partial word is dropped and no register changes. The next frame starts counting from bit 15 again.
- R4: Falling `sclk` edges after the 16th one in the same frame are ignored.
- R5: A control word stores bits [13:0]. The outputs take these bits: bit 0 is `core_reset_o`, bit 1 is `dac_sleep_o`, bit 2 is `table_bypass_o`, bit 3 is `msb_out_o` and bit 4 is `div2_o`. A control write never changes the frequency or phase registers, even when bit 0 is set.
- R6: While control bit 13 is 0, a frequency write places data bits [13:0] in bits [27:14] of the addressed register if control bit 12 is 1, and in bits [13:0] if control bit 12 is 0. The other half keeps its value.
- R7: While control bit 13 is 1, the first write to a frequency address only stages its 14 bits and changes no output. The next write to the same address loads {second data, staged data} into all 28 bits at once.
- R8: In the paired mode, a write to the other frequency address while a half is staged discards the staged half and becomes the new lower half. A control write also discards a staged half.
- R9: For a phase word, bit 13 picks phase register 1 (1) or phase register 0 (0). Bits [11:0] are stored and bit 12 is ignored.
- R10: Each accepted word changes the outputs on a single master clock edge. This edge is no later than the fourth rising `clk` edge after the 16th falling `sclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock of the synthesis core |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| sclk | input | 1 | Serial clock, data sampled on falling edge |
| sdata | input | 1 | Serial data, most significant bit first |
| fsync_n | input | 1 | Active-low frame select |
| freq0_o | output | 28 | Frequency tuning register 0 |
| freq1_o | output | 28 | Frequency tuning register 1 |
| phase0_o | output | 12 | Phase offset register 0 |
| phase1_o | output | 12 | Phase offset register 1 |
| core_reset_o | output | 1 | Control bit 0: hold the synthesis core in reset |
| dac_sleep_o | output | 1 | Control bit 1: power down the converter |
| table_bypass_o | output | 1 | Control bit 2: bypass the sine table |
| msb_out_o | output | 1 | Control bit 3: output the most significant bit |
| div2_o | output | 1 | Control bit 4: divide the most significant bit output by two |

## Verification
A word moves through two synchronizer flops, an edge detector and an update register. Its result is therefore due on the register outputs within four master clock edges after the last falling serial edge. The scoreboard monitor waits eight master clock cycles after the frame closes before it compares each expected snapshot. One dedicated check samples a frequency output just after the 16th falling edge, where the old value is still expected. It samples again six cycles later, where the new value is expected, to pin the latency window from both sides. Staged first halves and dropped or overlong frames are checked by confirming at the outputs that nothing changed.

// File: rtl/slr_pkg.sv
package slr_pkg;
    localparam int WORD_W  = 16;
    localparam int HALF_W  = 14;
    localparam int FREQ_W  = 2 * HALF_W;
    localparam int PHASE_W = 12;
    localparam int NUM_REG = 2;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    // control bit positions
    localparam int CB_RESET  = 0;
    localparam int CB_SLEEP  = 1;
    localparam int CB_BYPASS = 2;
    localparam int CB_MSB    = 3;
    localparam int CB_DIV2   = 4;
    localparam int CB_UPPER  = 12;
    localparam int CB_PAIRED = 13;
    localparam int PH_SEL    = 13;

    typedef enum logic [1:0] {
        ADR_CTL = 2'b00,
        ADR_F0  = 2'b01,
        ADR_F1  = 2'b10,
        ADR_PH  = 2'b11
    } adr_e;
endpackage

// File: rtl/slr_shifter.sv
module slr_shifter
    import slr_pkg::*;
(
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              fsync_n,
    output logic [WORD_W-1:0] word_o,
    output logic              tog_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
    } frm_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              tog;
    } hold_t;

    frm_t  frm_d, frm_q;
    hold_t hold_d, hold_q;
    logic  frame_rst;

    assign frame_rst = fsync_n | ~rst_n;

    always_comb begin
        frm_d  = frm_q;
        hold_d = hold_q;
        if (frm_q.cnt < CNT_W'(WORD_W)) begin
            frm_d.sh  = {frm_q.sh[WORD_W-2:0], sdata};
            frm_d.cnt = frm_q.cnt + 1'b1;
            if (frm_q.cnt == CNT_W'(WORD_W - 1)) begin
                hold_d.word = {frm_q.sh[WORD_W-2:0], sdata};
                hold_d.tog  = ~hold_q.tog;
            end
        end
    end

    always_ff @(negedge sclk or posedge frame_rst) begin
        if (frame_rst) frm_q <= '0;
        else           frm_q <= frm_d;
    end

    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign word_o = hold_q.word;
    assign tog_o  = hold_q.tog;

    // R2: the 16th sampled bit publishes a word
    p_word_on_last_bit_r2: assert property (@(negedge sclk) disable iff (frame_rst)
        (frm_q.cnt == CNT_W'(WORD_W - 1)) |=> (tog_o != $past(tog_o)));

    // R4: once a frame is full, further edges leave the published word alone
    p_extra_bits_ignored_r4: assert property (@(negedge sclk) disable iff (frame_rst)
        (frm_q.cnt == CNT_W'(WORD_W)) |=> ($stable(tog_o) && $stable(word_o)));
endmodule

// File: rtl/slr_sync.sv
module slr_sync
    import slr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tog_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              upd_o,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        logic [STAGES:0]   sy;
        logic              upd;
        logic [WORD_W-1:0] word;
    } sync_t;

    sync_t s_d, s_q;
    logic  edge_seen;

    assign edge_seen = s_q.sy[STAGES] ^ s_q.sy[STAGES-1];

    always_comb begin
        s_d     = s_q;
        s_d.sy  = {s_q.sy[STAGES-1:0], tog_i};
        s_d.upd = edge_seen;
        if (edge_seen) s_d.word = word_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign upd_o  = s_q.upd;
    assign word_o = s_q.word;

    // R10: each word yields a single-cycle update strobe
    p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);
endmodule

// File: rtl/slr_regfile.sv
module slr_regfile
    import slr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            upd_i,
    input  logic [WORD_W-1:0]               word_i,
    output logic [NUM_REG-1:0][FREQ_W-1:0]  freq_o,
    output logic [NUM_REG-1:0][PHASE_W-1:0] phase_o,
    output logic [HALF_W-1:0]               ctl_o
);
    typedef struct packed {
        logic [HALF_W-1:0]               ctl;
        logic [NUM_REG-1:0][FREQ_W-1:0]  freq;
        logic [NUM_REG-1:0][PHASE_W-1:0] phase;
        logic [HALF_W-1:0]               stage;
        logic                            pend;
        logic                            pend_sel;
    } rf_t;

    rf_t  r_d, r_q;
    adr_e adr;
    logic [HALF_W-1:0] data;
    logic              sel;
    logic [FREQ_W-1:0] cur;

    assign adr  = adr_e'(word_i[WORD_W-1:WORD_W-2]);
    assign data = word_i[HALF_W-1:0];
    assign sel  = (adr == ADR_F1);

    always_comb begin
        r_d = r_q;
        cur = r_q.freq[sel];
        if (upd_i) begin
            unique case (adr)
                ADR_CTL: begin
                    r_d.ctl  = data;
                    r_d.pend = 1'b0;
                end
                ADR_F0, ADR_F1: begin
                    if (r_q.ctl[CB_PAIRED]) begin
                        if (r_q.pend && (r_q.pend_sel == sel)) begin
                            r_d.freq[sel] = {data, r_q.stage};
                            r_d.pend      = 1'b0;
                        end else begin
                            r_d.stage    = data;
                            r_d.pend     = 1'b1;
                            r_d.pend_sel = sel;
                        end
                    end else begin
                        if (r_q.ctl[CB_UPPER]) cur[FREQ_W-1:HALF_W] = data;
                        else                   cur[HALF_W-1:0]      = data;
                        r_d.freq[sel] = cur;
                    end
                end
                ADR_PH: begin
                    r_d.phase[data[PH_SEL]] = data[PHASE_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign freq_o  = r_q.freq;
    assign phase_o = r_q.phase;
    assign ctl_o   = r_q.ctl;

    // R10: register outputs move only in the cycle after an update strobe
    p_change_needs_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(freq_o) || !$stable(phase_o) || !$stable(ctl_o)) |-> $past(upd_i));

    // R5: a control word leaves the tuning registers untouched
    p_ctl_keeps_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && adr == ADR_CTL) |=> ($stable(freq_o) && $stable(phase_o)));

    // R9: only phase words reach the phase registers
    p_phase_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && adr != ADR_PH) |=> $stable(phase_o));

    // R7: a first half in paired mode is staged, never shown
    p_first_half_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && ctl_o[CB_PAIRED] && (adr == ADR_F0 || adr == ADR_F1) && !r_q.pend)
        |=> $stable(freq_o));
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
    import slr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               sdata,
    input  logic               fsync_n,
    output logic [FREQ_W-1:0]  freq0_o,
    output logic [FREQ_W-1:0]  freq1_o,
    output logic [PHASE_W-1:0] phase0_o,
    output logic [PHASE_W-1:0] phase1_o,
    output logic               core_reset_o,
    output logic               dac_sleep_o,
    output logic               table_bypass_o,
    output logic               msb_out_o,
    output logic               div2_o
);
    logic [WORD_W-1:0]               ser_word, clk_word;
    logic                            ser_tog, upd;
    logic [NUM_REG-1:0][FREQ_W-1:0]  freq;
    logic [NUM_REG-1:0][PHASE_W-1:0] phase;
    logic [HALF_W-1:0]               ctl;
    logic                            unused_ctl;

    slr_shifter u_shift (
        .rst_n   (rst_n),
        .sclk    (sclk),
        .sdata   (sdata),
        .fsync_n (fsync_n),
        .word_o  (ser_word),
        .tog_o   (ser_tog)
    );

    slr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tog_i  (ser_tog),
        .word_i (ser_word),
        .upd_o  (upd),
        .word_o (clk_word)
    );

    slr_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (upd),
        .word_i  (clk_word),
        .freq_o  (freq),
        .phase_o (phase),
        .ctl_o   (ctl)
    );

    assign freq0_o        = freq[0];
    assign freq1_o        = freq[1];
    assign phase0_o       = phase[0];
    assign phase1_o       = phase[1];
    assign core_reset_o   = ctl[CB_RESET];
    assign dac_sleep_o    = ctl[CB_SLEEP];
    assign table_bypass_o = ctl[CB_BYPASS];
    assign msb_out_o      = ctl[CB_MSB];
    assign div2_o         = ctl[CB_DIV2];
    assign unused_ctl     = ^ctl[CB_PAIRED:CB_DIV2+1];
endmodule

// File: tb/sim_serial_reg_loader.sv
module sim_serial_reg_loader;
    logic clk = 0, rst_n = 0, sclk = 1, sdata = 0, fsync_n = 1;
    logic [27:0] freq0_o, freq1_o;
    logic [11:0] phase0_o, phase1_o;
    logic core_reset_o, dac_sleep_o, table_bypass_o, msb_out_o, div2_o;

    always #2 clk = ~clk;

    serial_reg_loader u0 (.*);

    typedef struct packed {
        logic [27:0] f0, f1;
        logic [11:0] p0, p1;
        logic [4:0]  c;
    } snap_t;

    snap_t exp_q[$];
    string tag_q[$];
    int checks = 0, errors = 0;
    event frame_done;

    // reference model state, kept from the requirements
    logic [27:0] m_f0 = 0, m_f1 = 0;
    logic [11:0] m_p0 = 0, m_p1 = 0;
    logic [13:0] m_ctl = 0, m_stage = 0;
    logic        m_pend = 0, m_psel = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic snap_t model_snap();
        return '{f0: m_f0, f1: m_f1, p0: m_p0, p1: m_p1, c: m_ctl[4:0]};
    endfunction

    function automatic void model_apply(input logic [15:0] w);
        logic        s;
        logic [27:0] cur;
        case (w[15:14])
            2'b00: begin m_ctl = w[13:0]; m_pend = 0; end
            2'b01, 2'b10: begin
                s = (w[15:14] == 2'b10);
                if (m_ctl[13]) begin
                    if (m_pend && m_psel == s) begin
                        if (s) m_f1 = {w[13:0], m_stage}; else m_f0 = {w[13:0], m_stage};
                        m_pend = 0;
                    end else begin
                        m_stage = w[13:0]; m_pend = 1; m_psel = s;
                    end
                end else begin
                    cur = s ? m_f1 : m_f0;
                    if (m_ctl[12]) cur[27:14] = w[13:0]; else cur[13:0] = w[13:0];
                    if (s) m_f1 = cur; else m_f0 = cur;
                end
            end
            default: if (w[13]) m_p1 = w[11:0]; else m_p0 = w[11:0];
        endcase
    endfunction

    task automatic shift_bits(input logic [31:0] w, input int n);
        fsync_n = 0;
        #20;
        for (int i = 0; i < n; i++) begin
            sclk = 1; sdata = w[n-1-i]; #20;
            sclk = 0; #20;
        end
        sclk = 1; #10;
        fsync_n = 1; #20;
    endtask

    task automatic post(input string tag);
        exp_q.push_back(model_snap());
        tag_q.push_back(tag);
        -> frame_done;
        repeat (12) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w, input string tag);
        shift_bits({16'h0, w}, 16);
        model_apply(w);
        post(tag);
    endtask

    // monitor: pops expected snapshots once each result is due
    initial forever begin
        snap_t e;
        string t;
        @(frame_done);
        repeat (8) @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "freq0", {4'h0, freq0_o}, {4'h0, e.f0});
        chk(t, "freq1", {4'h0, freq1_o}, {4'h0, e.f1});
        chk(t, "phase0", {20'h0, phase0_o}, {20'h0, e.p0});
        chk(t, "phase1", {20'h0, phase1_o}, {20'h0, e.p1});
        chk(t, "ctl", {27'h0, div2_o, msb_out_o, table_bypass_o, dac_sleep_o, core_reset_o},
            {27'h0, e.c});
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [27:0] old_f0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "freq0", {4'h0, freq0_o}, 0);
        chk("R1", "freq1", {4'h0, freq1_o}, 0);
        chk("R1", "phases", {8'h0, phase0_o, phase1_o}, 0);
        chk("R1", "ctl", {27'h0, div2_o, msb_out_o, table_bypass_o, dac_sleep_o, core_reset_o}, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);

        send(16'h0000, "R2");
        send(16'h4000 | 16'h1234, "R6");   // lower half of freq0
        send(16'h1000, "R5");              // select upper half
        send(16'h4000 | 16'h2ABC, "R6");   // upper half of freq0
        send(16'h8000 | 16'h3FFF, "R2");   // freq1 address decode

        send(16'h2000, "R5");              // paired mode
        send(16'h4000 | 16'h0111, "R7");   // staged only
        send(16'h4000 | 16'h0222, "R7");   // full word
        send(16'h8000 | 16'h0AAA, "R7");
        send(16'h4000 | 16'h0555, "R8");   // other address restarts pairing
        send(16'h4000 | 16'h0666, "R8");
        send(16'h8000 | 16'h0001, "R7");
        send(16'h201F, "R8");              // control write drops staged half
        send(16'h8000 | 16'h0002, "R8");
        send(16'h8000 | 16'h0003, "R8");

        send(16'hC000 | 16'h1ABC, "R9");   // bit 12 ignored
        send(16'hE000 | 16'h0123, "R9");

        // R3: frame dropped after 9 bits
        shift_bits({16'h0, 16'hC000 | 16'h0F0F}, 9);
        post("R3");
        send(16'hC000 | 16'h0456, "R3");   // next frame counts afresh

        // R4: four extra ones after the word
        shift_bits({12'h0, 16'hE000 | 16'h0777, 4'hF}, 20);
        model_apply(16'hE000 | 16'h0777);
        post("R4");

        // R10: latency window of a single update
        send(16'h0000, "R5");
        old_f0 = m_f0;
        fsync_n = 0; #20;
        for (int i = 0; i < 16; i++) begin
            sclk = 1; sdata = (16'h4000 | 16'h0F0F) >> (15 - i); #20;
            sclk = 0; if (i < 15) #20;
        end
        #1;
        chk("R10", "freq0 before due", {4'h0, freq0_o}, {4'h0, old_f0});
        model_apply(16'h4000 | 16'h0F0F);
        repeat (6) @(negedge clk);
        chk("R10", "freq0 when due", {4'h0, freq0_o}, {4'h0, m_f0});
        sclk = 1; #10; fsync_n = 1; #20;

        // R5: core reset flag set, registers kept
        send(16'h0001, "R5");
        send(16'h001E, "R5");

        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule